// File: doc/BRIEF.md
# Virtual Link Transmit Shaper

This block decides, for a parameterized set of virtual links (up to 128), which link may start its next frame on a shared transmit medium. Each link has a configured exponent k (0 to 7) that sets its minimum start-to-start spacing to 2^k milliseconds. External queues raise one "frame waiting" flag per link. The block holds a countdown per link, timed by a 1 µs tick input. Among the links that are both waiting and past their spacing, it picks one in rotating order. It then issues a single grant, which stays up until the transmit side reports that the frame has gone out.

Every grant carries the link number and an 8-bit sequence number kept per link. It also raises a request toward port A and, unless the link is set as single-port, toward port B. The block measures how many microseconds an eligible, waiting link sat idle before it was granted. It flags the grant when that wait exceeds a configured jitter limit. The limit is clamped to 500 µs inside the block. The integrator computes the limit from link frame sizes and line rate. Frame data movement, framing, CRC and queue storage are handled elsewhere.

Top module: `vls_shaper`

## Requirements
- R1: While reset is high and in the first cycle after it, `gnt_vld`, `port_a_req`, `port_b_req` and `jit_viol` are 0. The first grant of every link after reset carries sequence number 0.
- R2: A link with exponent k is never granted twice with fewer than US_PER_MS·2^k ticks between the two grants. A link that is always waiting, with each grant released at once, is granted exactly every US_PER_MS·2^k ticks.
- R3: At most one grant is outstanding. `gnt_vld`, `gnt_vl` and `gnt_seq` hold steady until `tx_done` is seen. The grant drops in the cycle after `tx_done`. A `tx_done` pulse while no grant is up has no effect.
- R4: When several links are eligible, the winner is the first one found scanning upward, with wrap-around, from the link after the last granted one. After reset the scan starts at link 0.
- R5: Each grant of a link stamps that link's current sequence number and then advances it by one. After 255 the next value is 1, never 0.
- R6: `port_a_req` is 1 whenever a grant is up. `port_b_req` equals `port_a_req` unless the granted link's bit in `cfg_single_port` is 1, in which case `port_b_req` is 0.
- R7: `jit_viol` is 1 during a grant when the ticks the granted link spent eligible and waiting, before the grant, exceed min(`cfg_jit_lim_us`, 500).
- R8: A link whose spacing has run out while nothing was waiting stays eligible. When its flag rises while the block is idle, the grant appears at the next clock edge.
- R9: A link's spacing countdown restarts at its grant, not at `tx_done`. If a grant is held longer than the spacing, the link can be granted again in the cycle right after the grant drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse once per microsecond |
| vl_pend | input | NUM_VL | Per-link frame waiting flag |
| cfg_gap_exp | input | 3·NUM_VL | Per-link spacing exponent k, link i in bits [3i+2:3i] |
| cfg_single_port | input | NUM_VL | Per-link: 1 = request port A only |
| cfg_jit_lim_us | input | 10 | Jitter limit in µs (clamped to 500) |
| tx_done | input | 1 | Transmit side finished the granted frame |
| gnt_vld | output | 1 | A grant is outstanding |
| gnt_vl | output | $clog2(NUM_VL) | Granted link number |
| gnt_seq | output | 8 | Sequence number stamped on the granted frame |
| port_a_req | output | 1 | Transmit request toward port A |
| port_b_req | output | 1 | Transmit request toward port B |
| jit_viol | output | 1 | Granted frame exceeded the jitter limit |

## Verification
The spacing is swept over all eight exponents with one link always waiting and each grant released at once. The measured tick distance tells an exact reload apart from an off-by-one or a wrong shift. All links waiting together show the rotation and the per-link single-port bit. Sparse waiting sets placed after a long idle period separate true rotation from fixed priority and confirm the one-edge start of an already eligible link. Held grants of chosen lengths place the wait just above and just below the configured limit, and past the 500 µs clamp. A grant held longer than the spacing shows whether the countdown restarts at the grant or at the release. A run of 260 grants crosses the sequence wrap.

// File: rtl/vls_pkg.sv
package vls_pkg;

    localparam int SEQ_W      = 8;
    localparam int EXP_W      = 3;
    localparam int WAIT_W     = 10;
    localparam int JIT_CAP_US = 500;
    localparam int MAX_VL     = 128;

    typedef logic [SEQ_W-1:0]  seq_t;
    typedef logic [WAIT_W-1:0] wait_t;

    // registered grant record
    typedef struct packed {
        logic vld;
        logic dual;
        logic viol;
        seq_t seq;
    } stamp_t;

    // next sequence value: 255 wraps to 1
    function automatic seq_t seq_next(input seq_t s);
        return (s == seq_t'(255)) ? seq_t'(1) : seq_t'(s + seq_t'(1));
    endfunction

    // spacing length in microsecond ticks
    function automatic int unsigned gap_ticks(input logic [EXP_W-1:0] k,
                                              input int unsigned us_per_ms);
        return us_per_ms << k;
    endfunction

    // clamp the configured jitter limit
    function automatic wait_t clamp_lim(input wait_t lim);
        return (lim > wait_t'(JIT_CAP_US)) ? wait_t'(JIT_CAP_US) : lim;
    endfunction

endpackage

// File: rtl/vls_vl_state.sv
module vls_vl_state
    import vls_pkg::*;
#(
    parameter int unsigned US_PER_MS = 1000,
    parameter int          GAP_W     = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             pend,
    input  logic [EXP_W-1:0] gap_exp,
    input  logic             win,
    input  wait_t            lim,
    output logic             elig,
    output seq_t             seq,
    output logic             viol
);

    logic [GAP_W-1:0] gap_q;
    wait_t            wait_q;
    seq_t             seq_q;

    localparam wait_t WAIT_SAT = '1;

    // spacing countdown, reloaded at the grant itself
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (win) begin
            gap_q <= GAP_W'(gap_ticks(gap_exp, US_PER_MS));
        end else if (tick && gap_q != '0) begin
            gap_q <= gap_q - GAP_W'(1);
        end
    end

    assign elig = (gap_q == '0);

    // time spent eligible and waiting
    always_ff @(posedge clk) begin
        if (rst || win || !pend) begin
            wait_q <= '0;
        end else if (tick && elig && wait_q != WAIT_SAT) begin
            wait_q <= wait_q + wait_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
        end else if (win) begin
            seq_q <= seq_next(seq_q);
        end
    end

    assign seq  = seq_q;
    assign viol = (wait_q > lim);

    AST_NO_EARLY_WIN: assert property (@(posedge clk) disable iff (rst)
        win |-> (gap_q == '0)) else $error("link granted inside its spacing"); // R2

    AST_SEQ_WRAP: assert property (@(posedge clk) disable iff (rst)
        (win && seq_q == seq_t'(255)) |=> (seq_q == seq_t'(1))) else $error("sequence wrap wrong"); // R5

    AST_SEQ_NONZERO: assert property (@(posedge clk) disable iff (rst)
        win |=> (seq_q != '0)) else $error("sequence returned to zero"); // R5

    AST_WIN_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        win |-> pend) else $error("grant without waiting frame"); // R4

endmodule

// File: rtl/vls_rr_arb.sv
module vls_rr_arb #(
    parameter int NUM_VL = 4,
    parameter int IDW    = 2
) (
    input  logic [NUM_VL-1:0] req,
    input  logic [IDW-1:0]    last_id,
    output logic [NUM_VL-1:0] gnt,
    output logic [IDW-1:0]    gnt_id,
    output logic              any
);

    // scan upward from the link after the last winner
    always_comb begin
        gnt    = '0;
        gnt_id = '0;
        any    = 1'b0;
        for (int unsigned off = 1; off <= NUM_VL; off++) begin
            int unsigned idx;
            idx = (int'(last_id) + off) % NUM_VL;
            if (!any && req[idx]) begin
                any      = 1'b1;
                gnt[idx] = 1'b1;
                gnt_id   = IDW'(idx);
            end
        end
    end

endmodule

// File: rtl/vls_shaper.sv
module vls_shaper
    import vls_pkg::*;
#(
    parameter int          NUM_VL    = 4,
    parameter int unsigned US_PER_MS = 1000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick_us,
    input  logic [NUM_VL-1:0]         vl_pend,
    input  logic [NUM_VL*EXP_W-1:0]   cfg_gap_exp,
    input  logic [NUM_VL-1:0]         cfg_single_port,
    input  logic [WAIT_W-1:0]         cfg_jit_lim_us,
    input  logic                      tx_done,
    output logic                      gnt_vld,
    output logic [((NUM_VL > 1) ? $clog2(NUM_VL) : 1)-1:0] gnt_vl,
    output logic [SEQ_W-1:0]          gnt_seq,
    output logic                      port_a_req,
    output logic                      port_b_req,
    output logic                      jit_viol
);

    localparam int IDW   = (NUM_VL > 1) ? $clog2(NUM_VL) : 1;
    localparam int GAP_W = $clog2(US_PER_MS * 128 + 1);

    generate
        if (NUM_VL > MAX_VL || NUM_VL < 2) begin : g_bad_count
            $error("NUM_VL must lie in 2..128");
        end
    endgenerate

    logic [NUM_VL-1:0] elig_v;
    logic [NUM_VL-1:0] viol_v;
    logic [NUM_VL-1:0] arb_req;
    logic [NUM_VL-1:0] arb_gnt;
    logic [NUM_VL-1:0] win_v;
    logic [IDW-1:0]    arb_id;
    logic              arb_any;
    seq_t              seq_a [NUM_VL];
    wait_t             lim_eff;

    stamp_t            gnt_q;
    logic [IDW-1:0]    id_q;
    logic [IDW-1:0]    last_q;

    assign lim_eff = clamp_lim(cfg_jit_lim_us);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_VL; gi++) begin : g_vl
            vls_vl_state #(
                .US_PER_MS (US_PER_MS),
                .GAP_W     (GAP_W)
            ) vl_i (
                .clk     (clk),
                .rst     (rst),
                .tick    (tick_us),
                .pend    (vl_pend[gi]),
                .gap_exp (cfg_gap_exp[gi*EXP_W +: EXP_W]),
                .win     (win_v[gi]),
                .lim     (lim_eff),
                .elig    (elig_v[gi]),
                .seq     (seq_a[gi]),
                .viol    (viol_v[gi])
            );
        end
    endgenerate

    assign arb_req = vl_pend & elig_v;

    vls_rr_arb #(
        .NUM_VL (NUM_VL),
        .IDW    (IDW)
    ) arb_i (
        .req     (arb_req),
        .last_id (last_q),
        .gnt     (arb_gnt),
        .gnt_id  (arb_id),
        .any     (arb_any)
    );

    // arbitration only while no grant is outstanding
    assign win_v = gnt_q.vld ? '0 : arb_gnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q  <= '0;
            id_q   <= '0;
            last_q <= IDW'(NUM_VL - 1);
        end else if (!gnt_q.vld) begin
            if (arb_any) begin
                gnt_q.vld  <= 1'b1;
                gnt_q.dual <= !cfg_single_port[arb_id];
                gnt_q.viol <= viol_v[arb_id];
                gnt_q.seq  <= seq_a[arb_id];
                id_q       <= arb_id;
                last_q     <= arb_id;
            end
        end else if (tx_done) begin
            gnt_q <= '0;
        end
    end

    assign gnt_vld    = gnt_q.vld;
    assign gnt_vl     = id_q;
    assign gnt_seq    = gnt_q.seq;
    assign port_a_req = gnt_q.vld;
    assign port_b_req = gnt_q.vld & gnt_q.dual;
    assign jit_viol   = gnt_q.vld & gnt_q.viol;

    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (gnt_vld && !tx_done) |=> (gnt_vld && $stable(gnt_vl) && $stable(gnt_seq)))
        else $error("grant changed before release"); // R3

    AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (gnt_vld && tx_done) |=> !gnt_vld) else $error("grant not released"); // R3

    AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(arb_gnt)) else $error("several links picked"); // R4

    AST_ARB_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (arb_gnt & ~arb_req) == '0) else $error("ineligible link picked"); // R4

    AST_B_NEEDS_A: assert property (@(posedge clk) disable iff (rst)
        port_b_req |-> port_a_req) else $error("port B alone"); // R6

    AST_SINGLE_PORT: assert property (@(posedge clk) disable iff (rst)
        port_b_req |-> !cfg_single_port[gnt_vl]) else $error("single-port link sent to B"); // R6

endmodule

// File: tb/vls_shaper_tb.sv
module vls_shaper_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NV  = 4;
    localparam int UPM = 2;
    localparam int IW  = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            tick_us = 1'b0;
    logic [NV-1:0]   vl_pend = '0;
    logic [NV*3-1:0] cfg_gap_exp = '0;
    logic [NV-1:0]   cfg_single_port = '0;
    logic [9:0]      cfg_jit_lim_us = 10'd500;
    logic            tx_done = 1'b0;
    logic            gnt_vld;
    logic [IW-1:0]   gnt_vl;
    logic [7:0]      gnt_seq;
    logic            port_a_req, port_b_req, jit_viol;

    always #2.5 clk = ~clk;

    vls_shaper #(.NUM_VL(NV), .US_PER_MS(UPM)) dut_i (
        .clk(clk), .rst(rst), .tick_us(tick_us), .vl_pend(vl_pend),
        .cfg_gap_exp(cfg_gap_exp), .cfg_single_port(cfg_single_port),
        .cfg_jit_lim_us(cfg_jit_lim_us), .tx_done(tx_done),
        .gnt_vld(gnt_vld), .gnt_vl(gnt_vl), .gnt_seq(gnt_seq),
        .port_a_req(port_a_req), .port_b_req(port_b_req), .jit_viol(jit_viol)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    bit auto_done = 1, auto_clear = 0, man_req = 0;
    int cyc = 0, tick_n = 0, g_n = 0;
    int g_id [512], g_seq [512], g_tick [512];
    bit g_a [512], g_b [512], g_v [512];
    bit prev_vld = 0;

    // monitor: samples outputs, drives done and tick at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            g_n = 0;
            prev_vld = 0;
        end else begin
            if (gnt_vld && !prev_vld) begin
                g_id[g_n % 512]   = int'(gnt_vl);
                g_seq[g_n % 512]  = int'(gnt_seq);
                g_tick[g_n % 512] = tick_n;
                g_a[g_n % 512]    = port_a_req;
                g_b[g_n % 512]    = port_b_req;
                g_v[g_n % 512]    = jit_viol;
                if (auto_clear) vl_pend[gnt_vl] = 1'b0;
                g_n++;
            end
            prev_vld = gnt_vld;
        end
        tx_done = (auto_done && gnt_vld) || man_req;
        man_req = 0;
        tick_us = (cyc % 4 == 0);
        if (tick_us) tick_n++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst = 1; vl_pend = '0; auto_done = 1; auto_clear = 0;
        cfg_gap_exp = '0; cfg_single_port = '0; cfg_jit_lim_us = 10'd500;
        repeat (3) @(negedge clk);
        #1 rst = 0;
    endtask

    task automatic wait_grants(input int n);
        while (g_n < n) @(negedge clk);
    endtask

    task automatic jit_trial(input int lim, input int hold, input bit exp_v);
        do_reset();
        cfg_jit_lim_us = 10'(lim);
        auto_done = 0;
        vl_pend = 4'b0001;
        wait_grants(1);
        #1 vl_pend = 4'b0011;
        repeat (hold * 4) @(negedge clk);
        #1 man_req = 1;
        wait_grants(2);
        chk(g_id[1] == 1, "R7 link", g_id[1], 1);
        chk(g_v[1] == exp_v, "R7 viol", int'(g_v[1]), int'(exp_v));
        chk(g_v[0] == 0, "R7 first", int'(g_v[0]), 0);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!gnt_vld && !port_a_req && !port_b_req && !jit_viol, "R1 reset",
            int'({gnt_vld, port_a_req, port_b_req, jit_viol}), 0);
        #1 rst = 0;
        @(negedge clk);
        chk(!gnt_vld, "R1 after reset", int'(gnt_vld), 0);

        // R2 spacing sweep over every exponent
        for (int k = 0; k < 8; k++) begin
            do_reset();
            cfg_gap_exp[2:0] = 3'(k);
            vl_pend = 4'b0001;
            wait_grants(3);
            chk(g_seq[0] == 0, "R1 first seq", g_seq[0], 0);
            chk(g_tick[1] - g_tick[0] == (UPM << k), "R2 spacing", g_tick[1] - g_tick[0], UPM << k);
            chk(g_tick[2] - g_tick[1] == (UPM << k), "R2 spacing", g_tick[2] - g_tick[1], UPM << k);
        end

        // R5 sequence run across the wrap
        do_reset();
        vl_pend = 4'b0001;
        wait_grants(260);
        for (int i = 0; i < 260; i++) begin
            int e;
            e = (i == 0) ? 0 : ((i - 1) % 255) + 1;
            chk(g_seq[i] == e, "R5 seq", g_seq[i], e);
        end

        // R4 rotation with all waiting, R6 port requests
        do_reset();
        cfg_single_port = 4'b1010;
        vl_pend = 4'b1111;
        wait_grants(8);
        for (int i = 0; i < 8; i++) begin
            chk(g_id[i] == i % 4, "R4 rotation", g_id[i], i % 4);
            chk(g_a[i] == 1, "R6 port A", int'(g_a[i]), 1);
            chk(g_b[i] == !cfg_single_port[i % 4], "R6 port B", int'(g_b[i]),
                int'(!cfg_single_port[i % 4]));
        end

        // R8 eligible link starts at the next edge; R4 sparse sets
        do_reset();
        auto_clear = 1;
        repeat (40) @(negedge clk);
        #1 vl_pend = 4'b1000;
        @(negedge clk);
        chk(gnt_vld && gnt_vl == 2'd3, "R8 immediate", int'({gnt_vld, gnt_vl}), 7);
        repeat (20) @(negedge clk);
        #1 vl_pend = 4'b0101;
        wait_grants(3);
        chk(g_id[1] == 0, "R4 wrap", g_id[1], 0);
        chk(g_id[2] == 2, "R4 next", g_id[2], 2);
        repeat (20) @(negedge clk);
        #1 vl_pend = 4'b1010;
        wait_grants(5);
        chk(g_id[3] == 3, "R4 after 2", g_id[3], 3);
        chk(g_id[4] == 1, "R4 wrap 2", g_id[4], 1);

        // R3 hold and R9 restart at grant
        do_reset();
        cfg_gap_exp[2:0] = 3'd1;
        auto_done = 0;
        vl_pend = 4'b0001;
        wait_grants(1);
        repeat (40) @(negedge clk);
        chk(gnt_vld && gnt_vl == 0 && g_n == 1, "R3 hold", g_n, 1);
        #1 man_req = 1;
        @(negedge clk);
        @(negedge clk);
        chk(!gnt_vld, "R3 release", int'(gnt_vld), 0);
        @(negedge clk);
        chk(gnt_vld && gnt_seq == 8'd1, "R9 regrant", int'(gnt_seq), 1);
        #1 vl_pend = 4'b0000; man_req = 1;
        repeat (30) @(negedge clk);
        #1 man_req = 1;
        repeat (4) @(negedge clk);
        chk(!gnt_vld, "R3 idle done", int'(gnt_vld), 0);
        #1 vl_pend = 4'b0001;
        @(negedge clk);
        chk(gnt_vld && gnt_seq == 8'd2, "R3 idle done seq", int'(gnt_seq), 2);

        // R7 jitter limit and clamp
        jit_trial(20, 26, 1'b1);
        jit_trial(20, 14, 1'b0);
        jit_trial(300, 290, 1'b0);
        jit_trial(511, 506, 1'b1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule